// File: doc/BRIEF.md
# LCD Display Timing Generator

This block generates the horizontal sync, vertical sync and data-enable timing for a parallel LCD panel. It also reports the pixel coordinate inside the visible image. Software programs the timing through a small memory-mapped register bus. Each axis has four fields: sync width, back porch, active resolution and front porch. Each line runs in this order: sync pulse, back porch, active pixels, front porch. A frame runs the same order, counted in lines.

Software can read the live horizontal and vertical position counters at any time. Two shift registers and a scaled-width register place the software image inside the panel's active area. The data-enable window starts at the shift offset. Its width is the scaled X resolution horizontally and the Y resolution vertically. Timing writes go to a pending copy of the registers. That copy is moved into the working copy only at a frame boundary, or at any time while the generator is stopped, so a frame never mixes old and new settings.

Top module: `lcd_timing_gen`

## Requirements
- R1: The run control is the two-bit field wdata[1:0] at word address 0. Timing runs only when this field holds 3. With any other value, the counters are held at 0 and hsync, vsync, de, pix_x and pix_y are all 0. Every register resets to 0.
- R2: Word addresses are as follows. Address 4 is X back porch, 5 is X sync width, 6 is X front porch and 7 is X resolution. Addresses 8 to 11 hold the same four fields for Y, in the same order. Address 12 is the live horizontal counter and 13 is the live vertical counter; both are read-only. Address 14 is X shift, 15 is Y shift and 16 is scaled X resolution. Address 17 reads back the Y resolution. A writable register reads back the last value written to it. Writes to 12, 13 and 17 are ignored. Unmapped addresses read as 0.
- R3: Within a line, hsync is 1 for the first (X sync width) counts. The back porch follows, then (X resolution) active counts, then the front porch. The line length is the sum of the four X fields.
- R4: Within a frame, vsync is 1 for the first (Y sync width) lines. The Y back porch, active and front porch lines follow in that order. The frame length is the sum of the four Y fields.
- R5: While running, the horizontal counter (address 12) increments every clock and returns to 0 after (line length - 1).
- R6: The vertical counter (address 13) advances only when a line ends, and returns to 0 after (frame length - 1).
- R7: Let p be the position counted from the first active pixel of the line. The horizontal window is open when p is below the X resolution, p >= X shift, and p - X shift is below the scaled X resolution. pix_x is then p - X shift.
- R8: Let q be the line counted from the first active line. The vertical window is open when q is below the Y resolution, q >= Y shift, and q - Y shift is below the Y resolution. pix_y is then q - Y shift.
- R9: de is 1 only when both windows are open. When de is 0, pix_x and pix_y are 0. de is never 1 while hsync or vsync is 1.
- R10: A timing register write made while running takes effect from the first cycle of the next frame. While stopped, written values are taken up on the next clock.
- R11: Each field may hold up to 2^CW-1. Line and frame lengths up to 4*(2^CW-1) count correctly, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | CW | Register write data |
| bus_rdata | output | CW+2 | Register read data, combinational from bus_addr |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable for the shifted image window |
| pix_x | output | CW | Image column while de is 1, else 0 |
| pix_y | output | CW | Image row while de is 1, else 0 |

## Verification
The bench builds the block with CW = 8. Small field values (one to five counts) then give frames of a few dozen cycles, so many complete frames, frame-boundary updates and window clipping cases fit in a short run. The same width lets every field be set to its largest value, 255. That exercises line lengths of 1020, which need the counter's two extra bits and reach the R11 limit exactly. A cycle-by-cycle reference model runs alongside the design and compares hsync, vsync, de and the pixel coordinates on every clock.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
// Package: register word addresses and field indices shared by the
// LCD timing generator. Assumes a fixed 5-bit word address map.
package lcdt_pkg;
    localparam int ADDR_W     = 5;
    localparam int NUM_FIELDS = 11;

    localparam logic [ADDR_W-1:0] A_RUN    = 5'd0;
    localparam logic [ADDR_W-1:0] A_XBP    = 5'd4;
    localparam logic [ADDR_W-1:0] A_YRES   = 5'd11;
    localparam logic [ADDR_W-1:0] A_HPOS   = 5'd12;
    localparam logic [ADDR_W-1:0] A_VPOS   = 5'd13;
    localparam logic [ADDR_W-1:0] A_XSHIFT = 5'd14;
    localparam logic [ADDR_W-1:0] A_YSHIFT = 5'd15;
    localparam logic [ADDR_W-1:0] A_XSCALE = 5'd16;
    localparam logic [ADDR_W-1:0] A_YSCALE = 5'd17;

    // Field indices: per axis a, base a*4 holds bp, sw, fp, res
    localparam int F_BP     = 0;
    localparam int F_SW     = 1;
    localparam int F_FP     = 2;
    localparam int F_RES    = 3;
    localparam int F_XSHIFT = 8;
    localparam int F_XSCALE = 10;
    localparam int F_YRES   = 7;

    // Map a word address to its timing field index, -1 when none
    function automatic int field_of(input logic [ADDR_W-1:0] a);
        if (a >= A_XBP && a <= A_YRES) return int'(a) - int'(A_XBP);
        if (a >= A_XSHIFT && a <= A_XSCALE) return int'(a) - int'(A_XSHIFT) + F_XSHIFT;
        return -1;
    endfunction
endpackage

// File: rtl/lcdt_regs.sv
`timescale 1ns/1ps
// Register file: run control, pending timing fields and their working
// copy, plus the combinational read mux. Assumes single-cycle writes and
// that the caller raises load only at a frame boundary or while stopped.
module lcdt_regs
    import lcdt_pkg::*;
#(
    parameter int CW = 12,
    parameter int TW = CW + 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [CW-1:0]                   wdata,
    input  logic                            load,
    input  logic [TW-1:0]                   hpos,
    input  logic [TW-1:0]                   vpos,
    output logic [1:0]                      run_field,
    output logic [NUM_FIELDS-1:0][CW-1:0]   act,
    output logic [TW-1:0]                   rdata
);
    logic [NUM_FIELDS-1:0][CW-1:0] pend;
    int                            wsel;

    assign wsel = field_of(addr);

    // Run control register: takes effect on the next clock
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_field <= 2'b00;
        else if (wr && addr == A_RUN) run_field <= wdata[1:0];
    end

    // Pending fields take writes; working copy follows on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            act  <= '0;
        end else begin
            if (load) act <= pend;
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (wr && wsel == i) pend[i] <= wdata;
            end
        end
    end

    // Read mux: pending fields, live counters, Y resolution alias
    always_comb begin
        rdata = '0;
        if (wsel >= 0) rdata = TW'(pend[wsel]);
        else if (addr == A_RUN)    rdata = TW'(run_field);
        else if (addr == A_HPOS)   rdata = hpos;
        else if (addr == A_VPOS)   rdata = vpos;
        else if (addr == A_YSCALE) rdata = TW'(pend[F_YRES]);
    end
endmodule

// File: rtl/lcdt_axis_cnt.sv
`timescale 1ns/1ps
// Axis position counter: advances on step, wraps after total-1, held at
// zero while stopped. Assumes total may be anywhere from 0 to 2^TW-1.
module lcdt_axis_cnt #(
    parameter int TW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [TW-1:0] total,
    output logic [TW-1:0] cnt,
    output logic          wrap
);
    logic [TW:0] nxt;

    assign nxt  = {1'b0, cnt} + 1'b1;
    assign wrap = run && step && (nxt >= {1'b0, total});

    // Count, wrap at the end of the period, clear while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (step)      cnt <= wrap ? '0 : nxt[TW-1:0];
    end
endmodule

// File: rtl/lcdt_axis_dec.sv
`timescale 1ns/1ps
// Axis decoder: from a position count and one axis's fields, derives the
// sync flag, the shifted image window and the coordinate inside it.
// Purely combinational; assumes cnt is TW = CW+2 bits.
module lcdt_axis_dec #(
    parameter int CW = 12,
    parameter int TW = CW + 2
) (
    input  logic [TW-1:0] cnt,
    input  logic [CW-1:0] sw,
    input  logic [CW-1:0] bp,
    input  logic [CW-1:0] res,
    input  logic [CW-1:0] shift,
    input  logic [CW-1:0] span,
    output logic          sync,
    output logic          inwin,
    output logic [CW-1:0] coord
);
    logic [TW-1:0] start, rel, off;
    logic          in_act;

    // Window arithmetic in TW bits so no sum can overflow
    always_comb begin
        start  = TW'(sw) + TW'(bp);
        rel    = cnt - start;
        off    = rel - TW'(shift);
        in_act = (cnt >= start) && (rel < TW'(res));
        inwin  = in_act && (rel >= TW'(shift)) && (off < TW'(span));
        sync   = cnt < TW'(sw);
        coord  = inwin ? off[CW-1:0] : '0;
    end
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
// LCD timing generator top: register file, horizontal and vertical
// counters, and one window decoder per axis. Outputs are combinational
// from registered counters and the working field copy.
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int CW = 12,
    localparam int TW = CW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [TW-1:0]     bus_rdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [CW-1:0]     pix_x,
    output logic [CW-1:0]     pix_y
);
    logic [1:0]                    run_field;
    logic                          run, load, x_wrap, frame_end;
    logic [NUM_FIELDS-1:0][CW-1:0] act;
    logic [TW-1:0]                 h_cnt, v_cnt, x_total, y_total;
    logic [1:0][TW-1:0]            cnt_a;
    logic [1:0]                    sync_a, win_a;
    logic [1:0][CW-1:0]            coord_a;

    assign run       = (run_field == 2'b11);
    assign load      = !run || frame_end;
    assign x_total   = TW'(act[F_SW]) + TW'(act[F_BP]) + TW'(act[F_RES]) + TW'(act[F_FP]);
    assign y_total   = TW'(act[4+F_SW]) + TW'(act[4+F_BP]) + TW'(act[4+F_RES]) + TW'(act[4+F_FP]);
    assign cnt_a[0]  = h_cnt;
    assign cnt_a[1]  = v_cnt;

    lcdt_regs #(.CW(CW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .load(load), .hpos(h_cnt), .vpos(v_cnt),
        .run_field(run_field), .act(act), .rdata(bus_rdata)
    );

    lcdt_axis_cnt #(.TW(TW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
        .total(x_total), .cnt(h_cnt), .wrap(x_wrap)
    );

    lcdt_axis_cnt #(.TW(TW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .run(run), .step(x_wrap),
        .total(y_total), .cnt(v_cnt), .wrap(frame_end)
    );

    // One decoder per axis; X spans the scaled width, Y its own resolution
    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam int B  = a * 4;
        localparam int SP = (a == 0) ? F_XSCALE : F_YRES;
        lcdt_axis_dec #(.CW(CW), .TW(TW)) u_dec (
            .cnt(cnt_a[a]), .sw(act[B+F_SW]), .bp(act[B+F_BP]),
            .res(act[B+F_RES]), .shift(act[F_XSHIFT+a]), .span(act[SP]),
            .sync(sync_a[a]), .inwin(win_a[a]), .coord(coord_a[a])
        );
    end

    assign hsync = run && sync_a[0];
    assign vsync = run && sync_a[1];
    assign de    = run && win_a[0] && win_a[1];
    assign pix_x = de ? coord_a[0] : '0;
    assign pix_y = de ? coord_a[1] : '0;
endmodule

// File: rtl/lcdt_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the timing generator, bound to the top.
module lcdt_checker
    import lcdt_pkg::*;
#(
    parameter int CW = 12,
    parameter int TW = CW + 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          run,
    input logic                          x_wrap,
    input logic                          frame_end,
    input logic                          hsync,
    input logic                          vsync,
    input logic                          de,
    input logic [TW-1:0]                 h_cnt,
    input logic [TW-1:0]                 v_cnt,
    input logic [NUM_FIELDS-1:0][CW-1:0] act
);
    p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h_cnt == '0 && v_cnt == '0));

    p_h_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !x_wrap) |=> (!run || h_cnt == TW'($past(h_cnt) + 1'b1)));

    p_h_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        x_wrap |=> (h_cnt == '0));

    p_v_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !x_wrap) |=> $stable(v_cnt));

    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> $stable(act));

    p_de_no_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));
endmodule

bind lcd_timing_gen lcdt_checker #(.CW(CW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .x_wrap(x_wrap),
    .frame_end(frame_end), .hsync(hsync), .vsync(vsync), .de(de),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .act(act)
);

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
// Directed bench with a cycle-level reference model of the timing.
module sim_lcd_timing_gen;
    localparam int CW = 8;
    localparam int TW = CW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [TW-1:0] bus_rdata;
    logic          hsync, vsync, de;
    logic [CW-1:0] pix_x, pix_y;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_on = 0;

    // Reference model state
    int mp [0:17];
    int ma [0:17];
    int mrun_f = 0;
    int mh = 0;
    int mv = 0;

    lcd_timing_gen #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Model update at each clock edge, written from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 18; i++) begin mp[i] = 0; ma[i] = 0; end
            mrun_f = 0; mh = 0; mv = 0;
        end else begin
            automatic bit run = (mrun_f == 3);
            automatic int xt = ma[4] + ma[5] + ma[6] + ma[7];
            automatic int yt = ma[8] + ma[9] + ma[10] + ma[11];
            automatic bit xw = run && (mh + 1 >= xt);
            automatic bit fw = xw && (mv + 1 >= yt);
            if (!run || fw) for (int i = 4; i < 17; i++) ma[i] = mp[i];
            if (!run) begin mh = 0; mv = 0; end
            else begin
                mh = xw ? 0 : mh + 1;
                if (xw) mv = fw ? 0 : mv + 1;
            end
            if (bus_wr) begin
                if (bus_addr == 0) mrun_f = int'(bus_wdata) & 3;
                else if ((bus_addr >= 4 && bus_addr <= 11) || (bus_addr >= 14 && bus_addr <= 16))
                    mp[bus_addr] = int'(bus_wdata);
            end
        end
    end

    // Per-cycle comparison of outputs with the model (R3, R4, R7, R8, R9)
    always @(negedge clk) begin
        if (mon_on) begin
            automatic bit run = (mrun_f == 3);
            automatic int px = mh - ma[5] - ma[4];
            automatic int qy = mv - ma[9] - ma[8];
            automatic bit xin = (px >= 0) && (px < ma[7]) && (px >= ma[14]) && (px - ma[14] < ma[16]);
            automatic bit yin = (qy >= 0) && (qy < ma[11]) && (qy >= ma[15]) && (qy - ma[15] < ma[11]);
            automatic bit ede = run && xin && yin;
            chk("R3 hsync", int'(hsync), int'(run && mh < ma[5]));
            chk("R4 vsync", int'(vsync), int'(run && mv < ma[9]));
            chk("R9 de", int'(de), int'(ede));
            chk("R7 pix_x", int'(pix_x), ede ? px - ma[14] : 0);
            chk("R8 pix_y", int'(pix_y), ede ? qy - ma[15] : 0);
        end
    end

    // Bus helpers, called at a falling edge
    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = a[4:0]; bus_wdata = d[CW-1:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = a[4:0];
        #1 v = int'(bus_rdata);
    endtask

    task automatic cfg(input int xs, xb, xr, xf, ys, yb, yr, yf, xsh, ysh, xsc);
        wr(0, 0);
        wr(5, xs); wr(4, xb); wr(7, xr); wr(6, xf);
        wr(9, ys); wr(8, yb); wr(11, yr); wr(10, yf);
        wr(14, xsh); wr(15, ysh); wr(16, xsc);
        wr(0, 3);
    endtask

    task automatic wait_pos(input int h, input int v);
        do @(negedge clk); while (!(mh == h && mv == v));
    endtask

    task automatic t_reset;
        int v;
        chk("R1 reset hsync", int'(hsync), 0);
        chk("R1 reset de", int'(de), 0);
        chk("R1 reset pix_x", int'(pix_x), 0);
        rd(7, v);  chk("R1 reset xres", v, 0);
        rd(12, v); chk("R1 reset hpos", v, 0);
    endtask

    task automatic t_regmap;
        int v;
        for (int a = 4; a <= 16; a++) if (a != 12 && a != 13) wr(a, 16 + a);
        for (int a = 4; a <= 16; a++) if (a != 12 && a != 13) begin
            rd(a, v); chk("R2 readback", v, 16 + a);
        end
        rd(17, v); chk("R2 yscale alias", v, 27);
        wr(12, 77); rd(12, v); chk("R2 hpos read-only", v, 0);
        wr(17, 5);  rd(17, v); chk("R2 yscale read-only", v, 27);
        wr(20, 9);  rd(20, v); chk("R2 unmapped", v, 0);
        wr(0, 2);   rd(0, v);  chk("R2 run field", v, 2);
    endtask

    task automatic t_basic;
        int v;
        cfg(2, 3, 4, 2, 1, 2, 3, 1, 0, 0, 4);
        repeat (80) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rd(12, v); chk("R5 hpos", v, mh);
            rd(13, v); chk("R6 vpos", v, mv);
        end
        wait_pos(10, 2); rd(12, v); chk("R5 hpos last", v, 10);
        @(negedge clk); rd(12, v); chk("R5 hpos wrap", v, 0);
        rd(13, v); chk("R6 vpos advance", v, 3);
        repeat (200) @(negedge clk);
    endtask

    task automatic de_count(input string req, input int frame_len, input int expected);
        int n = 0;
        wait_pos(0, 0);
        for (int i = 0; i < frame_len; i++) begin
            if (de) n++;
            @(negedge clk);
        end
        chk(req, n, expected);
    endtask

    task automatic t_shift;
        cfg(1, 1, 4, 1, 1, 1, 3, 1, 1, 1, 2);
        de_count("R7 R8 shifted window count", 42, 4);
        cfg(1, 1, 4, 1, 1, 1, 3, 1, 2, 0, 10);
        de_count("R7 scaled width clipped", 42, 6);
        repeat (100) @(negedge clk);
    endtask

    task automatic t_shadow;
        cfg(2, 1, 3, 1, 1, 1, 2, 1, 0, 0, 3);
        wait_pos(0, 2);
        wr(5, 5);
        wait_pos(3, 3); chk("R10 old sync kept", int'(hsync), 0);
        wait_pos(3, 0); chk("R10 new sync applied", int'(hsync), 1);
        repeat (100) @(negedge clk);
    endtask

    task automatic t_stop;
        int v;
        wr(0, 1);
        chk("R1 stopped hsync", int'(hsync), 0);
        chk("R1 stopped de", int'(de), 0);
        @(negedge clk);
        rd(12, v); chk("R1 stopped hpos", v, 0);
        rd(13, v); chk("R1 stopped vpos", v, 0);
        wr(0, 2); repeat (5) @(negedge clk);
        chk("R1 value 2 idle", int'(vsync), 0);
    endtask

    task automatic t_max;
        int v;
        cfg(255, 255, 255, 255, 1, 0, 1, 0, 0, 0, 255);
        wait_pos(1019, 0); rd(12, v); chk("R11 hpos max", v, 1019);
        wait_pos(0, 1);    rd(13, v); chk("R11 vpos", v, 1);
        de_count("R11 de per frame", 2040, 255);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;
        t_reset();
        t_regmap();
        t_basic();
        t_shift();
        t_shadow();
        t_stop();
        t_max();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule